// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block is the software-visible register bank of a clock generator. It holds the loop multiplier and the reference divider settings, the PLL control bits and the bus and module clock source selects. It also reports lock and limp-home status, each with a sticky change flag that software clears by writing a 1. Software reaches it through a plain byte-wide address/data bus. Writes take effect on the clock edge, and reads are combinational from the address. Transfers are never stalled, so the bus has no valid/ready handshake and no back-pressure.

Four status inputs come from the analog side: lock detected, reference clock lost, PLL supply good, and special mode. The first three are asynchronous, so each passes through a two-flop synchronizer. The block drives the effective control outputs that the clock muxes and the PLL use: PLL enable, loop bandwidth, bus clock source and module clock source. It also drives one interrupt request.

Limp-home mode overrides some of these outputs. While it is active, read-back still shows the bits that software latched. Other rules protect a running system. Settings that shape the PLL output are frozen while the PLL clocks the bus. The PLL cannot be switched off under the bus, and the bus cannot be moved onto a PLL that is off.

Register offsets on `bus_addr`:
- 0 is the multiplier.
- 1 is the reference divider.
- 2 holds the status and flags.
- 3 is the control register.
- 4 is the clock select register.

Unmapped offsets read 0.

Top module: `clkgen_regbank`

## Requirements
- R1: The multiplier (offset 0) keeps a 6-bit field in bits 5..0, and the reference divider (offset 1) keeps a 3-bit field in bits 2..0. All other bits read 0, and both reset to 0.
- R2: Writes to offsets 0 and 1 are ignored while the bus-select-PLL bit (offset 4, bit 6) is 1.
- R3: At offset 2, bit 7 is the lock-change flag and bit 6 is lock status. Status inputs go through two synchronizer flops, and the status updates one cycle after that. The flag sets on every change of lock status in either direction. Writing 1 to bit 7 clears the flag, but a change event in the same cycle wins.
- R4: At offset 2, bit 0 is limp-home status (reference lost while no-limp-home is 0) and bit 1 is its change flag. The flag sets on entry and on exit, and writing 1 to bit 1 clears it.
- R5: Writes cannot change lock status. While in limp-home, lock status and the lock-change flag are held at 0.
- R6: At offset 3, the bits are: bit 7 lock interrupt enable, bit 6 PLL on, bit 5 auto bandwidth, bit 4 acquisition, bit 2 pseudo-stop, bit 1 limp-home interrupt enable, bit 0 no-limp-home. With supply good, it reads 0x60 after reset.
- R7: While the PLL supply is low, several bits are forced:
  - PLL on and both interrupt enables are forced to 0.
  - No-limp-home is forced to 1.
  - Bus-select-PLL is forced to 0.
- R8: PLL on cannot be cleared while bus-select-PLL is 1. Bus-select-PLL cannot be set while PLL on is 0.
- R9: With auto 1, the acquisition bit is read-only and reads lock status. With auto 0, it is written by software. `bw_low` follows the value that reads back.
- R10: In normal mode, no-limp-home takes its value from the first control write after reset only. In special mode, every control write updates it. While it is 1, a lost reference does not enter limp-home.
- R11: In limp-home, the outputs are forced as follows while offsets 3 and 4 still read the latched bits:
  - `pll_en` is forced to 1.
  - `bus_sel_pll` is forced to 1.
  - `mod_sel_slow` is forced to 0.
- R12: At offset 4, bit 6 is bus-select-PLL, bit 5 is bus-select-slow and bit 2 is module-clock-select slow. `bus_sel_slow` is 0 whenever `bus_sel_pll` is 1.
- R13: `irq` is 1 exactly when either of these holds:
  - the lock-change flag and the lock interrupt enable are both 1;
  - the limp-home flag and the limp-home interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| lock_in | input | 1 | Lock detector output (asynchronous) |
| ref_lost_in | input | 1 | Reference clock lost (asynchronous) |
| pll_pwr_ok | input | 1 | PLL supply good (asynchronous) |
| special_mode | input | 1 | Special mode, static |
| pll_en | output | 1 | Effective PLL enable |
| bw_low | output | 1 | Low loop bandwidth select |
| bus_sel_pll | output | 1 | Bus clock from PLL |
| bus_sel_slow | output | 1 | Bus clock from slow divider |
| mod_sel_slow | output | 1 | Module clock from slow divider |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `special_mode` is static.
- The three asynchronous status inputs hold each level for at least the two synchronizer cycles.
- There is at most one write per cycle, so each property can tie a register change to a single write or status edge.

The stimulus changes status inputs only on falling clock edges and waits four cycles before it checks the result. It drives every bus write for exactly one cycle. The one deliberate exception is the set-versus-clear collision, where a flag-clear write is timed onto the cycle in which the synchronized lock change arrives.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int MULT_W  = 6;
  localparam int REFDV_W = 3;

  localparam logic [ADDR_W-1:0] A_MULT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_REFDV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLKSEL = 3'd4;

  // bit positions that software decodes
  localparam int B_LOCKIF = 7;
  localparam int B_LOCK   = 6;
  localparam int B_LHIF   = 1;
  localparam int B_LHOME  = 0;
  localparam int B_BSPLL  = 6;
  localparam int B_BSSLOW = 5;
  localparam int B_MSLOW  = 2;

  typedef struct packed {
    logic lock_ie;
    logic pll_on;
    logic auto_bw;
    logic acq;
    logic pstop;
    logic lh_ie;
    logic no_lh;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{lock_ie: 1'b0, pll_on: 1'b1, auto_bw: 1'b1,
                                 acq: 1'b0, pstop: 1'b0, lh_ie: 1'b0, no_lh: 1'b0};
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkgen_status.sv
module clkgen_status (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_s,
  input  logic lost_s,
  input  logic no_lh,
  input  logic clr_lock,
  input  logic clr_lh,
  output logic lock_st,
  output logic lock_chg,
  output logic lh_st,
  output logic lh_chg
);
  logic lh_now, lock_now;
  logic lock_chg_n, lh_chg_n;

  assign lh_now   = lost_s & ~no_lh;
  assign lock_now = lock_s & ~lh_now;

  always_comb begin
    lh_chg_n = lh_chg;
    if (clr_lh) lh_chg_n = 1'b0;
    if (lh_now != lh_st) lh_chg_n = 1'b1;   // set beats clear

    lock_chg_n = lock_chg;
    if (clr_lock) lock_chg_n = 1'b0;
    if (lock_now != lock_st) lock_chg_n = 1'b1;
    if (lh_now) lock_chg_n = 1'b0;         // held clear in limp-home
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lh_st    <= 1'b0;
      lock_st  <= 1'b0;
      lh_chg   <= 1'b0;
      lock_chg <= 1'b0;
    end else begin
      lh_st    <= lh_now;
      lock_st  <= lock_now;
      lh_chg   <= lh_chg_n;
      lock_chg <= lock_chg_n;
    end
  end

  p_lock_clear_limp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lh_st |-> (!lock_st && !lock_chg));

  p_lock_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_now != lock_st && !lh_now) |=> lock_chg);

  p_lh_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lh_now != lh_st) |=> lh_chg);

  p_lh_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lh && lh_now == lh_st) |=> !lh_chg);
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pwr_ok_s,
  input  logic              special_mode,
  output logic [MULT_W-1:0] mult,
  output logic [REFDV_W-1:0] refdv,
  output ctrl_t             ctrl,
  output logic              bs_pll,
  output logic              bs_slow,
  output logic              ms_slow
);
  logic wr_mult, wr_refdv, wr_ctrl, wr_sel;
  logic nolh_done;
  ctrl_t ctrl_n;
  logic bs_pll_n, bs_slow_n, ms_slow_n;

  assign wr_mult  = bus_wr && bus_addr == A_MULT;
  assign wr_refdv = bus_wr && bus_addr == A_REFDV;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_sel   = bus_wr && bus_addr == A_CLKSEL;

  always_comb begin
    ctrl_n = ctrl;
    if (wr_ctrl) begin
      ctrl_n.lock_ie = bus_wdata[7];
      ctrl_n.pll_on  = bus_wdata[6] | bs_pll;
      ctrl_n.auto_bw = bus_wdata[5];
      if (!bus_wdata[5]) ctrl_n.acq = bus_wdata[4];
      ctrl_n.pstop   = bus_wdata[2];
      ctrl_n.lh_ie   = bus_wdata[1];
      if (special_mode || !nolh_done) ctrl_n.no_lh = bus_wdata[0];
    end
    bs_pll_n  = bs_pll;
    bs_slow_n = bs_slow;
    ms_slow_n = ms_slow;
    if (wr_sel) begin
      bs_pll_n  = bus_wdata[B_BSPLL] & ctrl.pll_on;
      bs_slow_n = bus_wdata[B_BSSLOW];
      ms_slow_n = bus_wdata[B_MSLOW];
    end
    if (!pwr_ok_s) begin
      ctrl_n.lock_ie = 1'b0;
      ctrl_n.pll_on  = 1'b0;
      ctrl_n.lh_ie   = 1'b0;
      ctrl_n.no_lh   = 1'b1;
      bs_pll_n       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult      <= '0;
      refdv     <= '0;
      ctrl      <= CTRL_RST;
      nolh_done <= 1'b0;
      bs_pll    <= 1'b0;
      bs_slow   <= 1'b0;
      ms_slow   <= 1'b0;
    end else begin
      if (wr_mult && !bs_pll)  mult  <= bus_wdata[MULT_W-1:0];
      if (wr_refdv && !bs_pll) refdv <= bus_wdata[REFDV_W-1:0];
      if (wr_ctrl) nolh_done <= 1'b1;
      ctrl    <= ctrl_n;
      bs_pll  <= bs_pll_n;
      bs_slow <= bs_slow_n;
      ms_slow <= ms_slow_n;
    end
  end

  p_div_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_pll && (wr_mult || wr_refdv)) |=> ($stable(mult) && $stable(refdv)));

  p_pll_under_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bs_pll |-> ctrl.pll_on);

  p_pwr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_s |=> (!ctrl.pll_on && !ctrl.lock_ie && !ctrl.lh_ie && ctrl.no_lh && !bs_pll));

  p_nolh_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nolh_done && !special_mode && pwr_ok_s) |=> $stable(ctrl.no_lh));
endmodule

// File: rtl/clkgen_regbank.sv
module clkgen_regbank
  import clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  input  logic              ref_lost_in,
  input  logic              pll_pwr_ok,
  input  logic              special_mode,
  output logic              pll_en,
  output logic              bw_low,
  output logic              bus_sel_pll,
  output logic              bus_sel_slow,
  output logic              mod_sel_slow,
  output logic              irq
);
  localparam int SW = 3;

  logic [SW-1:0] st_s;
  logic lock_s, lost_s, pwr_s;
  logic [MULT_W-1:0]  mult;
  logic [REFDV_W-1:0] refdv;
  ctrl_t ctrl;
  logic bs_pll, bs_slow, ms_slow;
  logic lock_st, lock_chg, lh_st, lh_chg;
  logic wr_flags, acq_rd;

  clkgen_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pll_pwr_ok, ref_lost_in, lock_in}), .q(st_s)
  );
  assign {pwr_s, lost_s, lock_s} = st_s;

  clkgen_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pwr_ok_s(pwr_s), .special_mode(special_mode),
    .mult(mult), .refdv(refdv), .ctrl(ctrl),
    .bs_pll(bs_pll), .bs_slow(bs_slow), .ms_slow(ms_slow)
  );

  assign wr_flags = bus_wr && bus_addr == A_FLAGS;

  clkgen_status u_status (
    .clk(clk), .rst_n(rst_n), .lock_s(lock_s), .lost_s(lost_s),
    .no_lh(ctrl.no_lh),
    .clr_lock(wr_flags && bus_wdata[B_LOCKIF]),
    .clr_lh(wr_flags && bus_wdata[B_LHIF]),
    .lock_st(lock_st), .lock_chg(lock_chg), .lh_st(lh_st), .lh_chg(lh_chg)
  );

  assign acq_rd = ctrl.auto_bw ? lock_st : ctrl.acq;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MULT:   bus_rdata[MULT_W-1:0]  = mult;
      A_REFDV:  bus_rdata[REFDV_W-1:0] = refdv;
      A_FLAGS: begin
        bus_rdata[B_LOCKIF] = lock_chg;
        bus_rdata[B_LOCK]   = lock_st;
        bus_rdata[B_LHIF]   = lh_chg;
        bus_rdata[B_LHOME]  = lh_st;
      end
      A_CTRL:   bus_rdata = {ctrl.lock_ie, ctrl.pll_on, ctrl.auto_bw, acq_rd,
                             1'b0, ctrl.pstop, ctrl.lh_ie, ctrl.no_lh};
      A_CLKSEL: begin
        bus_rdata[B_BSPLL]  = bs_pll;
        bus_rdata[B_BSSLOW] = bs_slow;
        bus_rdata[B_MSLOW]  = ms_slow;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign pll_en       = ctrl.pll_on | lh_st;
  assign bus_sel_pll  = bs_pll | lh_st;
  assign bus_sel_slow = bs_slow & ~bus_sel_pll;
  assign mod_sel_slow = ms_slow & ~lh_st;
  assign bw_low       = acq_rd;
  assign irq          = (lock_chg & ctrl.lock_ie) | (lh_chg & ctrl.lh_ie);

  p_limp_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lh_st |-> (pll_en && bus_sel_pll && !mod_sel_slow));

  p_slow_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_pll |-> !bus_sel_slow);

  p_irq_src_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lock_chg || lh_chg));
endmodule

// File: tb/tb_clkgen_regbank.sv
module tb_clkgen_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic lock_in = 1'b0, ref_lost_in = 1'b0, pll_pwr_ok = 1'b1, special_mode = 1'b0;
  logic pll_en, bw_low, bus_sel_pll, bus_sel_slow, mod_sel_slow, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkgen_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
    .ref_lost_in(ref_lost_in), .pll_pwr_ok(pll_pwr_ok), .special_mode(special_mode),
    .pll_en(pll_en), .bw_low(bw_low), .bus_sel_pll(bus_sel_pll),
    .bus_sel_slow(bus_sel_slow), .mod_sel_slow(mod_sel_slow), .irq(irq)
  );

  // {addr, write data, expected read-back}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'hFF, 8'h3F}, {3'd1, 8'hFF, 8'h07}, {3'd0, 8'h15, 8'h15},
    {3'd3, 8'h64, 8'h64}, {3'd3, 8'h65, 8'h64}, {3'd4, 8'h64, 8'h64},
    {3'd0, 8'h2A, 8'h15}, {3'd1, 8'h03, 8'h07}, {3'd3, 8'h24, 8'h64},
    {3'd4, 8'h00, 8'h00}, {3'd3, 8'h24, 8'h24}, {3'd4, 8'h40, 8'h00},
    {3'd3, 8'h14, 8'h14}, {3'd3, 8'hF6, 8'hE6}
  };

  function automatic string vreq(int i);
    case (i)
      0, 1, 2: return "R1";
      3, 4:    return "R10";
      5:       return "R12";
      6, 7:    return "R2";
      8, 10, 11: return "R8";
      9:       return "R12";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(3'd0, v); chk("R1", v, 8'h00);
    rd(3'd1, v); chk("R1", v, 8'h00);
    rd(3'd2, v); chk("R3", v, 8'h00);
    rd(3'd3, v); chk("R6", v, 8'h60);
    rd(3'd4, v); chk("R12", v, 8'h00);
    chk("R11", {7'd0, pll_en}, 8'h01);
    chk("R13", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk(vreq(i), v, VEC[i][7:0]);
    end
    rd(3'd2, v); chk("R5", v, 8'h00);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R5", v, 8'h00);

    // lock edges, flags, interrupt (ctrl = E6)
    @(negedge clk); lock_in = 1'b1; settle();
    rd(3'd2, v); chk("R3", v, 8'hC0);
    chk("R13", {7'd0, irq}, 8'h01);
    chk("R9", {7'd0, bw_low}, 8'h01);
    wr(3'd2, 8'h80);
    rd(3'd2, v); chk("R3", v, 8'h40);
    chk("R13", {7'd0, irq}, 8'h00);
    @(negedge clk); lock_in = 1'b0; settle();
    rd(3'd2, v); chk("R3", v, 8'h80);
    // set beats clear in the same cycle
    @(negedge clk); lock_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h80;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd2, v); chk("R3", v, 8'hC0);
    wr(3'd2, 8'h80);
    rd(3'd2, v); chk("R3", v, 8'h40);

    // limp-home
    wr(3'd4, 8'h04);
    chk("R12", {7'd0, mod_sel_slow}, 8'h01);
    @(negedge clk); ref_lost_in = 1'b1; settle();
    rd(3'd2, v); chk("R5", v, 8'h03);
    chk("R11", {5'd0, pll_en, bus_sel_pll, mod_sel_slow}, 8'h06);
    rd(3'd4, v); chk("R11", v, 8'h04);
    chk("R13", {7'd0, irq}, 8'h01);
    @(negedge clk); ref_lost_in = 1'b0; settle();
    rd(3'd2, v); chk("R4", v, 8'hC2);
    wr(3'd2, 8'h82);
    rd(3'd2, v); chk("R4", v, 8'h40);
    chk("R13", {7'd0, irq}, 8'h00);

    // bus-select-slow masked by bus-select-PLL
    wr(3'd4, 8'h20);
    chk("R12", {6'd0, bus_sel_pll, bus_sel_slow}, 8'h01);
    wr(3'd4, 8'h60);
    chk("R12", {6'd0, bus_sel_pll, bus_sel_slow}, 8'h02);

    // supply low
    @(negedge clk); pll_pwr_ok = 1'b0; settle();
    rd(3'd3, v); chk("R7", v, 8'h35);
    rd(3'd4, v); chk("R7", v, 8'h20);
    chk("R7", {7'd0, pll_en}, 8'h00);

    // special mode: no-limp-home rewritable, and it blocks limp-home
    @(negedge clk); pll_pwr_ok = 1'b1; special_mode = 1'b1; settle();
    wr(3'd3, 8'h60);
    rd(3'd3, v); chk("R10", v, 8'h70);
    wr(3'd3, 8'h61);
    rd(3'd3, v); chk("R10", v, 8'h71);
    @(negedge clk); ref_lost_in = 1'b1; settle();
    rd(3'd2, v); chk("R10", v & 8'h03, 8'h00);
    chk("R10", {7'd0, bus_sel_pll}, 8'h00);
    @(negedge clk); ref_lost_in = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule